// File: doc/BRIEF.md
# Fast-Lock Interval Controller

This block manages the brief high-current acquisition phase of a fractional-N synthesizer loop. It is clocked by the phase-detector clock. When a new frequency is loaded, or when the loop's power control goes from low to high, it opens a timed interval. During that interval it closes the loop-filter bypass switch and routes the phase-detector pulses to the high-current pump. Once the programmed number of phase-detector cycles has passed, it returns the pulses to the normal pump and opens the switch.

Software sets four things:
- an enable bit;
- a 13-bit interval length;
- a 3-bit current code for each pump;
- a tri-state bit and a polarity bit, which both pumps share.

Both the frequency-load strobe and the power edge restart the interval. A zero length is treated as one cycle. The current code presented to the analog side always belongs to the pump that is active at that moment.

Top module: `flk_ctrl`

## Requirements
- R1: While reset is asserted, the controller is out of the fast interval. `pump_sel_o` and `loop_sw_o` are 0, and `cur_code_o` equals `cp1_code_i`.
- R2: A high `freq_load_i` at a clock edge starts the fast interval from that edge, provided `fast_en_i` and `pwr_on_i` are both 1. During the interval `pump_sel_o`=1 (fast pump) and `loop_sw_o`=1.
- R3: The power control is sampled at each clock edge. A low-to-high change of `pwr_on_i` between two consecutive edges starts the fast interval in the same way as `freq_load_i`. Holding `pwr_on_i` high does not start the interval again.
- R4: After a start with length N, `pump_sel_o` and `loop_sw_o` stay 1 for exactly N clock cycles. After that both return to 0.
- R5: The length is taken from `fast_cnt_i` at the starting edge. A value of 0 gives one cycle. Changes to `fast_cnt_i` during an interval have no effect on that interval.
- R6: A new start during an interval reloads the full length from that edge.
- R7: If `fast_en_i` is 0 or `pwr_on_i` is 0, both `pump_sel_o` and `loop_sw_o` read 0 at once, and a running interval is cancelled at the next edge.
- R8: `cur_code_o` equals `cp2_code_i` while `pump_sel_o` is 1, and equals `cp1_code_i` otherwise.
- R9: The phase-detector pulses `pd_up_i` and `pd_dn_i` appear only on the active pump's outputs: `fast_up_o`/`fast_dn_o` when `pump_sel_o`=1, `norm_up_o`/`norm_dn_o` otherwise. The idle pump's outputs read 0.
- R10: With `cp_inv_i`=1, the up and down pulses are swapped before routing.
- R11: With `cp_hiz_i`=1, `pump_hiz_o` is 1 and all four pump pulse outputs are 0. Otherwise `pump_hiz_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-detector clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_on_i | input | 1 | Loop power control; a rising edge starts the interval |
| fast_en_i | input | 1 | Fast-lock enable |
| fast_cnt_i | input | 13 | Interval length in clock cycles (0 acts as 1) |
| freq_load_i | input | 1 | One-cycle strobe marking a frequency change |
| cp1_code_i | input | 3 | Normal pump current code |
| cp2_code_i | input | 3 | Fast pump current code |
| cp_hiz_i | input | 1 | Force both pumps to high impedance |
| cp_inv_i | input | 1 | Swap the up and down sense |
| pd_up_i | input | 1 | Phase-detector up pulse |
| pd_dn_i | input | 1 | Phase-detector down pulse |
| pump_sel_o | output | 1 | 1 selects the fast pump |
| loop_sw_o | output | 1 | Loop-filter bypass switch, 1 means closed |
| cur_code_o | output | 3 | Current code of the active pump |
| norm_up_o | output | 1 | Up pulse to the normal pump |
| norm_dn_o | output | 1 | Down pulse to the normal pump |
| fast_up_o | output | 1 | Up pulse to the fast pump |
| fast_dn_o | output | 1 | Down pulse to the fast pump |
| pump_hiz_o | output | 1 | Both pumps in high impedance |

## Verification
A wrong remaining count or a lost active flag shows up at `pump_sel_o` in the first cycle where the interval should have ended, or should have continued. The error is therefore visible within N+1 cycles of the start that caused it. A missed or false power-edge detection shows up one edge after the `pwr_on_i` change, as a missing or spurious start. Routing and polarity errors are visible in the same cycle as the pulse, because the steering path is combinational. The stimulus therefore compares every output every cycle against a model built from the requirements.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam int unsigned NUM_PUMPS = 2;

  typedef enum logic {
    PUMP_NORM = 1'b0,
    PUMP_FAST = 1'b1
  } pump_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pd_pulse_t;
endpackage

// File: rtl/flk_trigger.sv
module flk_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic freq_load_i,
  output logic fire_o
);
  logic pwr_q;
  logic pwr_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= 1'b0;
    else         pwr_q <= pwr_on_i;
  end

  assign pwr_rise = pwr_on_i & ~pwr_q;
  assign fire_o   = freq_load_i | pwr_rise;
endmodule

// File: rtl/flk_timer.sv
module flk_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] load_val;
  logic             act_q;

  assign load_val = (len_i == ZERO) ? ONE : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      left_q <= ZERO;
    end else if (clear_i) begin
      act_q  <= 1'b0;
      left_q <= ZERO;
    end else if (load_i) begin
      act_q  <= 1'b1;
      left_q <= load_val;
    end else if (act_q) begin
      if (left_q == ONE) begin
        act_q  <= 1'b0;
        left_q <= ZERO;
      end else begin
        left_q <= left_q - ONE;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/flk_pump_steer.sv
module flk_pump_steer
  import flk_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic                    sel_i,
  input  logic [CODE_W-1:0]       norm_code_i,
  input  logic [CODE_W-1:0]       fast_code_i,
  input  logic                    hiz_i,
  input  logic                    inv_i,
  input  pd_pulse_t               pd_i,
  output logic [CODE_W-1:0]       code_o,
  output logic [NUM_PUMPS-1:0]    up_o,
  output logic [NUM_PUMPS-1:0]    dn_o
);
  pd_pulse_t eff;
  pump_e     sel_e;

  assign sel_e  = pump_e'(sel_i);
  assign eff.up = inv_i ? pd_i.dn : pd_i.up;
  assign eff.dn = inv_i ? pd_i.up : pd_i.dn;
  assign code_o = (sel_e == PUMP_FAST) ? fast_code_i : norm_code_i;

  for (genvar g = 0; g < NUM_PUMPS; g++) begin : g_pump
    logic mine;
    assign mine    = (sel_e == pump_e'(g)) & ~hiz_i;
    assign up_o[g] = mine & eff.up;
    assign dn_o[g] = mine & eff.dn;
  end
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl
  import flk_pkg::*;
#(
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              fast_en_i,
  input  logic [CNT_W-1:0]  fast_cnt_i,
  input  logic              freq_load_i,
  input  logic [CODE_W-1:0] cp1_code_i,
  input  logic [CODE_W-1:0] cp2_code_i,
  input  logic              cp_hiz_i,
  input  logic              cp_inv_i,
  input  logic              pd_up_i,
  input  logic              pd_dn_i,
  output logic              pump_sel_o,
  output logic              loop_sw_o,
  output logic [CODE_W-1:0] cur_code_o,
  output logic              norm_up_o,
  output logic              norm_dn_o,
  output logic              fast_up_o,
  output logic              fast_dn_o,
  output logic              pump_hiz_o
);
  logic                 fire;
  logic                 active;
  logic                 allowed;
  logic                 fast_mode;
  logic [NUM_PUMPS-1:0] up_v;
  logic [NUM_PUMPS-1:0] dn_v;
  pd_pulse_t            pd;

  assign allowed = fast_en_i & pwr_on_i;

  flk_trigger u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_on_i    (pwr_on_i),
    .freq_load_i (freq_load_i),
    .fire_o      (fire)
  );

  flk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (~allowed),
    .load_i   (fire),
    .len_i    (fast_cnt_i),
    .active_o (active)
  );

  assign fast_mode = active & allowed;
  assign pd.up     = pd_up_i;
  assign pd.dn     = pd_dn_i;

  flk_pump_steer #(.CODE_W(CODE_W)) u_steer (
    .sel_i       (fast_mode),
    .norm_code_i (cp1_code_i),
    .fast_code_i (cp2_code_i),
    .hiz_i       (cp_hiz_i),
    .inv_i       (cp_inv_i),
    .pd_i        (pd),
    .code_o      (cur_code_o),
    .up_o        (up_v),
    .dn_o        (dn_v)
  );

  assign pump_sel_o = fast_mode;
  assign loop_sw_o  = fast_mode;
  assign norm_up_o  = up_v[PUMP_NORM];
  assign norm_dn_o  = dn_v[PUMP_NORM];
  assign fast_up_o  = up_v[PUMP_FAST];
  assign fast_dn_o  = dn_v[PUMP_FAST];
  assign pump_hiz_o = cp_hiz_i;
endmodule

// File: rtl/flk_ctrl_chk.sv
module flk_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_on_i,
  input logic fast_en_i,
  input logic freq_load_i,
  input logic pump_sel_o,
  input logic loop_sw_o,
  input logic norm_up_o,
  input logic norm_dn_o,
  input logic fast_up_o,
  input logic fast_dn_o,
  input logic pump_hiz_o
);
  logic pwr_seen_q;
  logic rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_seen_q <= 1'b0;
      rise_q     <= 1'b0;
    end else begin
      pwr_seen_q <= pwr_on_i;
      rise_q     <= pwr_on_i & ~pwr_seen_q;
    end
  end

  // R2: an enabled load closes the switch on the next cycle if still allowed
  a_r2_load_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_load_i && fast_en_i && pwr_on_i) ##1 (fast_en_i && pwr_on_i) |-> (pump_sel_o && loop_sw_o));

  // R3: an interval only begins after a load or a power rise
  a_r3_no_spurious_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_sel_o) |-> ($past(freq_load_i) || rise_q));

  // R7: disabled or unpowered means normal pump and open switch
  a_r7_disabled_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_en_i || !pwr_on_i) |-> (!pump_sel_o && !loop_sw_o));

  // R9: never drive both pumps at once
  a_r9_single_pump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((norm_up_o || norm_dn_o) && (fast_up_o || fast_dn_o)));

  // R11: high impedance silences every pump pulse
  a_r11_hiz_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_hiz_o |-> ($countones({norm_up_o, norm_dn_o, fast_up_o, fast_dn_o}) == 0));
endmodule

bind flk_ctrl flk_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_on_i    (pwr_on_i),
  .fast_en_i   (fast_en_i),
  .freq_load_i (freq_load_i),
  .pump_sel_o  (pump_sel_o),
  .loop_sw_o   (loop_sw_o),
  .norm_up_o   (norm_up_o),
  .norm_dn_o   (norm_dn_o),
  .fast_up_o   (fast_up_o),
  .fast_dn_o   (fast_dn_o),
  .pump_hiz_o  (pump_hiz_o)
);

// File: tb/flk_ctrl_tb_top.sv
module flk_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b0, fast_en = 1'b0, freq_load = 1'b0;
  logic [12:0] fast_cnt = '0;
  logic [2:0]  cp1 = 3'd2, cp2 = 3'd6;
  logic        hiz = 1'b0, inv = 1'b0, pd_up = 1'b0, pd_dn = 1'b0;
  logic        pump_sel, loop_sw, norm_up, norm_dn, fast_up, fast_dn, pump_hiz;
  logic [2:0]  cur_code;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic        m_act = 1'b0;
  int          m_left = 0;
  logic        m_pwr_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .fast_en_i(fast_en),
    .fast_cnt_i(fast_cnt), .freq_load_i(freq_load), .cp1_code_i(cp1),
    .cp2_code_i(cp2), .cp_hiz_i(hiz), .cp_inv_i(inv), .pd_up_i(pd_up),
    .pd_dn_i(pd_dn), .pump_sel_o(pump_sel), .loop_sw_o(loop_sw),
    .cur_code_o(cur_code), .norm_up_o(norm_up), .norm_dn_o(norm_dn),
    .fast_up_o(fast_up), .fast_dn_o(fast_dn), .pump_hiz_o(pump_hiz)
  );

  function automatic int eff_len(input logic [12:0] c);
    return (c == 13'd0) ? 1 : int'(c);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference behaviour applied at each clock edge (R2-R7)
  task automatic model_edge();
    logic rise;
    rise = pwr_on & ~m_pwr_prev;
    if (!pwr_on || !fast_en) begin
      m_act = 1'b0; m_left = 0;
    end else if (freq_load || rise) begin
      m_act = 1'b1; m_left = eff_len(fast_cnt);
    end else if (m_act) begin
      if (m_left == 1) begin m_act = 1'b0; m_left = 0; end
      else m_left--;
    end
    m_pwr_prev = pwr_on;
  endtask

  task automatic compare_all(input string tag);
    logic fm, eu, ed;
    fm = m_act & fast_en & pwr_on;
    eu = inv ? pd_dn : pd_up;
    ed = inv ? pd_up : pd_dn;
    chk({tag, "/R4"}, "pump_sel", pump_sel, fm);
    chk({tag, "/R4"}, "loop_sw", loop_sw, fm);
    chk({tag, "/R8"}, "cur_code", cur_code, fm ? cp2 : cp1);
    chk({tag, "/R11"}, "pump_hiz", pump_hiz, hiz);
    chk({tag, "/R9"}, "fast_up", fast_up, !hiz & fm & eu);
    chk({tag, "/R9"}, "fast_dn", fast_dn, !hiz & fm & ed);
    chk({tag, "/R10"}, "norm_up", norm_up, !hiz & !fm & eu);
    chk({tag, "/R10"}, "norm_dn", norm_dn, !hiz & !fm & ed);
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
    freq_load = 1'b0;
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_F1C5));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pump_sel", pump_sel, 0);
    chk("R1", "loop_sw", loop_sw, 0);
    chk("R1", "cur_code", cur_code, cp1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: power rising edge starts an interval of 5
    fast_en = 1'b1; fast_cnt = 13'd5; pwr_on = 1'b1;
    run("R3", 8);
    chk("R3", "held_high_no_restart", pump_sel, 0);

    // R2/R4: load with length 3
    fast_cnt = 13'd3; freq_load = 1'b1;
    cyc("R2");
    chk("R2", "started", pump_sel, 1);
    run("R4", 5);

    // R5: zero length gives one cycle; mid-interval length change ignored
    fast_cnt = 13'd0; freq_load = 1'b1;
    cyc("R5");
    chk("R5", "zero_len_first", pump_sel, 1);
    cyc("R5");
    chk("R5", "zero_len_over", pump_sel, 0);
    fast_cnt = 13'd4; freq_load = 1'b1;
    cyc("R5");
    fast_cnt = 13'd100;
    run("R5", 5);
    chk("R5", "len_change_ignored", pump_sel, 0);

    // R6: retrigger mid-interval reloads
    fast_cnt = 13'd6; freq_load = 1'b1;
    run("R6", 3);
    freq_load = 1'b1;
    run("R6", 9);

    // R7: disable cancels; load while disabled ignored; power low
    fast_cnt = 13'd10; freq_load = 1'b1;
    run("R7", 2);
    fast_en = 1'b0;
    run("R7", 2);
    fast_en = 1'b1;
    cyc("R7");
    chk("R7", "cancelled", pump_sel, 0);
    fast_en = 1'b0; freq_load = 1'b1;
    cyc("R7");
    fast_en = 1'b1;
    cyc("R7");
    chk("R7", "load_while_off", pump_sel, 0);
    freq_load = 1'b1;
    cyc("R7");
    pwr_on = 1'b0;
    cyc("R7");
    chk("R7", "pwr_low_off", pump_sel, 0);
    pwr_on = 1'b1; fast_cnt = 13'd2;
    run("R3", 4);

    // R9-R11: steering with fixed pulse patterns
    for (int k = 0; k < 16; k++) begin
      {hiz, inv, pd_up, pd_dn} = 4'(k);
      if (k == 8) begin fast_cnt = 13'd20; freq_load = 1'b1; end
      cyc("R9");
    end

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      freq_load = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) pwr_on = ~pwr_on;
      if ($urandom_range(0, 99) == 0) fast_en = ~fast_en;
      if ($urandom_range(0, 19) == 0) fast_cnt = 13'($urandom_range(0, 24));
      if (i == 2000) fast_cnt = 13'd8191;
      cp1 = 3'($urandom); cp2 = 3'($urandom);
      hiz = ($urandom_range(0, 7) == 0); inv = 1'($urandom);
      pd_up = 1'($urandom); pd_dn = 1'($urandom);
      cyc("RND");
    end

    // R4: full-length interval of 8191
    hiz = 1'b0; pwr_on = 1'b1; fast_en = 1'b1; fast_cnt = 13'd8191; freq_load = 1'b1;
    run("R4", 8193);
    chk("R4", "max_len_done", pump_sel, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule